// File: doc/BRIEF.md
# Configurable Data-Ready Generator

This block produces the active-low data-ready level for a converter that runs through a programmed sequence of steps. A two-bit mode input selects what pulls the level low. It can be every finished conversion, only the final conversion of each step, only the final conversion of the whole sequence, or the fill level of the result FIFO compared against a hysteresis band.

In the three event-driven modes, the level falls one cycle after a qualifying conversion strobe. A read strobe releases it: this strobe marks the eighth serial clock edge of a conversion-data read. If the level is still low when the next qualifying result arrives, a high pulse of `PULSE_CYC` clock cycles comes first, so that every new result gives a fresh falling edge.

In FIFO mode, two thresholds set the band, and they may be given in either order. The level falls when the depth rises above the larger threshold. It rises when the depth drops to or below the smaller one. Inside the band it holds its previous level.

Top module: `drdy_gen`

## Requirements
- R1: While reset is active, and in the first cycle after it, `drdy_n` is 1.
- R2: With mode code 2'b00, every `conv_done` strobe is a qualifying event, whatever the flags.
- R3: With mode code 2'b01, `conv_done` is a qualifying event only when `step_last` is 1 in the same cycle.
- R4: With mode code 2'b10, `conv_done` is a qualifying event only when `seq_last` is 1 in the same cycle.
- R5: A qualifying event while `drdy_n` is 1 and no pulse is pending drives `drdy_n` to 0 on the next clock edge.
- R6: A qualifying event while `drdy_n` is 0 drives `drdy_n` to 1 for exactly `PULSE_CYC` cycles. After those cycles it is 0.
- R7: In an event mode, `rd_strobe` without a qualifying event drives `drdy_n` to 1 on the next edge. When `rd_strobe` and a qualifying event come in the same cycle, the event is handled as in R5/R6, so the level ends at 0.
- R8: With mode code 2'b11, `fifo_depth` strictly greater than the larger of `thr_a`/`thr_b` drives `drdy_n` to 0 on the next edge.
- R9: In FIFO mode, `fifo_depth` less than or equal to the smaller of `thr_a`/`thr_b` drives `drdy_n` to 1 on the next edge.
- R10: In FIFO mode, a depth strictly between the two thresholds leaves `drdy_n` unchanged.
- R11: A cycle in which `mode` differs from its value in the previous cycle drives `drdy_n` to 1 on the next edge. It cancels any pending pulse and ignores any event in that cycle.
- R12: In FIFO mode, `conv_done` and `rd_strobe` have no effect on `drdy_n`.
- R13: While a high pulse is in progress, further events and read strobes are ignored. The pulse runs to its end and the level then goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Assertion policy: 00 each result, 01 step end, 10 sequence end, 11 FIFO level |
| conv_done | input | 1 | One-cycle strobe: a conversion result is available |
| step_last | input | 1 | Qualifies `conv_done`: this result ends a sequence step |
| seq_last | input | 1 | Qualifies `conv_done`: this result ends the whole sequence |
| rd_strobe | input | 1 | One-cycle strobe at the eighth serial clock edge of a data read |
| fifo_depth | input | DEPTH_W | Current number of results held in the FIFO |
| thr_a | input | DEPTH_W | First hysteresis threshold |
| thr_b | input | DEPTH_W | Second hysteresis threshold |
| drdy_n | output | 1 | Active-low data-ready level |

## Verification
The bench builds the block with `DEPTH_W = 4` and `PULSE_CYC = 2`. A four-bit depth makes it affordable to sweep every pair of thresholds in both orders against every depth, from both prior levels, so each hold case inside the band is covered. A two-cycle pulse separates a working pulse counter from one that stops after a single cycle. The event modes are run with scripted strobes over all four flag combinations, with reads coinciding with events, with events during a pulse, and with mode changes that cancel a pulse.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

  typedef enum logic [1:0] {
    MODE_EACH = 2'b00,
    MODE_STEP = 2'b01,
    MODE_SEQ  = 2'b10,
    MODE_FIFO = 2'b11
  } drdy_mode_e;

  // Does a conversion strobe count as an event under the given policy?
  function automatic logic event_qualifies(input drdy_mode_e m,
                                           input logic step_end,
                                           input logic seq_end);
    case (m)
      MODE_EACH: return 1'b1;
      MODE_STEP: return step_end;
      MODE_SEQ:  return seq_end;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/drdy_evt_qual.sv
module drdy_evt_qual
  import drdy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       conv_done,
  input  logic       step_last,
  input  logic       seq_last,
  input  logic       rd_strobe,
  output logic       mode_chg,
  output logic       is_fifo,
  output logic       evt,
  output logic       rd_req
);

  drdy_mode_e mode_q;
  drdy_mode_e mode_cur;

  assign mode_cur = drdy_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_EACH;
    else        mode_q <= mode_cur;
  end

  assign mode_chg = (mode_cur != mode_q);
  assign is_fifo  = (mode_cur == MODE_FIFO);
  assign evt      = conv_done && !is_fifo &&
                    event_qualifies(mode_cur, step_last, seq_last);
  assign rd_req   = rd_strobe && !is_fifo;

endmodule

// File: rtl/drdy_fifo_hyst.sv
module drdy_fifo_hyst #(
  parameter int DEPTH_W = 9
) (
  input  logic [DEPTH_W-1:0] fifo_depth,
  input  logic [DEPTH_W-1:0] thr_a,
  input  logic [DEPTH_W-1:0] thr_b,
  output logic               fifo_set,
  output logic               fifo_clr
);

  function automatic logic [DEPTH_W-1:0] band_top(input logic [DEPTH_W-1:0] x,
                                                  input logic [DEPTH_W-1:0] y);
    return (x >= y) ? x : y;
  endfunction

  function automatic logic [DEPTH_W-1:0] band_bot(input logic [DEPTH_W-1:0] x,
                                                  input logic [DEPTH_W-1:0] y);
    return (x >= y) ? y : x;
  endfunction

  logic [DEPTH_W-1:0] top_lvl;
  logic [DEPTH_W-1:0] bot_lvl;

  assign top_lvl  = band_top(thr_a, thr_b);
  assign bot_lvl  = band_bot(thr_a, thr_b);
  assign fifo_set = (fifo_depth > top_lvl);
  assign fifo_clr = (fifo_depth <= bot_lvl);

endmodule

// File: rtl/drdy_out_ctl.sv
module drdy_out_ctl #(
  parameter int PULSE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_chg,
  input  logic is_fifo,
  input  logic evt,
  input  logic rd_req,
  input  logic fifo_set,
  input  logic fifo_clr,
  output logic drdy_n
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] pulse_cnt;
  logic          pulse_busy;

  assign pulse_busy = (pulse_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_n    <= 1'b1;
      pulse_cnt <= '0;
    end else if (mode_chg) begin
      drdy_n    <= 1'b1;
      pulse_cnt <= '0;
    end else if (is_fifo) begin
      pulse_cnt <= '0;
      if (fifo_set)      drdy_n <= 1'b0;
      else if (fifo_clr) drdy_n <= 1'b1;
    end else if (pulse_busy) begin
      pulse_cnt <= pulse_cnt - CW'(1);
      if (pulse_cnt == CW'(1)) drdy_n <= 1'b0;
    end else if (evt) begin
      if (!drdy_n) begin
        drdy_n    <= 1'b1;
        pulse_cnt <= CW'(PULSE_CYC);
      end else begin
        drdy_n <= 1'b0;
      end
    end else if (rd_req) begin
      drdy_n <= 1'b1;
    end
  end

  assert_mode_change_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> drdy_n) else $error("mode change did not release drdy_n");

  assert_fifo_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fifo && !mode_chg && fifo_set) |=> !drdy_n) else $error("fifo set missed");

  assert_fifo_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fifo && !mode_chg && fifo_clr) |=> drdy_n) else $error("fifo clear missed");

  assert_fifo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fifo && !mode_chg && !fifo_set && !fifo_clr) |=> $stable(drdy_n))
    else $error("fifo band hold broken");

  assert_event_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fifo && !mode_chg && !pulse_busy && evt && drdy_n) |=> !drdy_n)
    else $error("event while high did not assert");

  assert_event_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fifo && !mode_chg && !pulse_busy && evt && !drdy_n) |=> drdy_n)
    else $error("event while low did not pulse high");

  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fifo && !mode_chg && !pulse_busy && !evt && rd_req) |=> drdy_n)
    else $error("read did not release drdy_n");

endmodule

// File: rtl/drdy_gen.sv
module drdy_gen #(
  parameter int DEPTH_W   = 9,
  parameter int PULSE_CYC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               conv_done,
  input  logic               step_last,
  input  logic               seq_last,
  input  logic               rd_strobe,
  input  logic [DEPTH_W-1:0] fifo_depth,
  input  logic [DEPTH_W-1:0] thr_a,
  input  logic [DEPTH_W-1:0] thr_b,
  output logic               drdy_n
);

  logic mode_chg;
  logic is_fifo;
  logic evt;
  logic rd_req;
  logic fifo_set;
  logic fifo_clr;

  drdy_evt_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .conv_done (conv_done),
    .step_last (step_last),
    .seq_last  (seq_last),
    .rd_strobe (rd_strobe),
    .mode_chg  (mode_chg),
    .is_fifo   (is_fifo),
    .evt       (evt),
    .rd_req    (rd_req)
  );

  drdy_fifo_hyst #(.DEPTH_W(DEPTH_W)) u_hyst (
    .fifo_depth (fifo_depth),
    .thr_a      (thr_a),
    .thr_b      (thr_b),
    .fifo_set   (fifo_set),
    .fifo_clr   (fifo_clr)
  );

  drdy_out_ctl #(.PULSE_CYC(PULSE_CYC)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_chg (mode_chg),
    .is_fifo  (is_fifo),
    .evt      (evt),
    .rd_req   (rd_req),
    .fifo_set (fifo_set),
    .fifo_clr (fifo_clr),
    .drdy_n   (drdy_n)
  );

  // R1: the output register resets to the released level
  assert_reset_high_R1: assert property (@(posedge clk)
    !rst_n |=> drdy_n) else $error("drdy_n not high after reset");

endmodule

// File: tb/sim_drdy_gen.sv
module sim_drdy_gen;

  localparam int DW = 4;
  localparam int PC = 2;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          conv_done = 1'b0;
  logic          step_last = 1'b0;
  logic          seq_last = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] fifo_depth = '0;
  logic [DW-1:0] thr_a = '0;
  logic [DW-1:0] thr_b = '0;
  logic          drdy_n;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  drdy_gen #(.DEPTH_W(DW), .PULSE_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .conv_done(conv_done),
    .step_last(step_last), .seq_last(seq_last), .rd_strobe(rd_strobe),
    .fifo_depth(fifo_depth), .thr_a(thr_a), .thr_b(thr_b), .drdy_n(drdy_n)
  );

  task automatic chk(input logic exp, input string req);
    n_chk++;
    if (drdy_n !== exp) begin
      n_err++;
      $display("FAIL %s: drdy_n=%b expected=%b at %0t", req, drdy_n, exp, $time);
    end
  endtask

  // advance one clock edge, return at the following falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    conv_done = 1'b0; step_last = 1'b0; seq_last = 1'b0; rd_strobe = 1'b0;
  endtask

  // single conversion strobe with flags, then idle inputs
  task automatic conv(input logic s, input logic q);
    conv_done = 1'b1; step_last = s; seq_last = q;
    cyc();
    clear_in();
  endtask

  task automatic rd();
    rd_strobe = 1'b1;
    cyc();
    clear_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(1'b1, "R1 in reset");
    cyc();
    rst_n = 1'b1;
    cyc();
    chk(1'b1, "R1 after reset");

    // ---- mode 00: each result
    conv(1'b0, 1'b0);
    chk(1'b0, "R2/R5 first result asserts");
    conv(1'b0, 1'b0);
    chk(1'b1, "R6 pulse cycle 1");
    cyc();
    chk(1'b1, "R6 pulse cycle 2");
    cyc();
    chk(1'b0, "R6 low after pulse");
    rd();
    chk(1'b1, "R7 read releases");
    cyc();
    chk(1'b1, "R7 stays released");
    conv_done = 1'b1; rd_strobe = 1'b1;
    cyc(); clear_in();
    chk(1'b0, "R7 event beats read while high");
    conv_done = 1'b1; rd_strobe = 1'b1;
    cyc(); clear_in();
    chk(1'b1, "R7 event+read while low pulses");
    cyc();
    chk(1'b1, "R7 pulse second cycle");
    cyc();
    chk(1'b0, "R7 ends low");

    // R13: event and read during the pulse
    conv(1'b0, 1'b0);
    chk(1'b1, "R13 pulse started");
    conv_done = 1'b1; rd_strobe = 1'b1;
    cyc(); clear_in();
    chk(1'b1, "R13 pulse continues");
    cyc();
    chk(1'b0, "R13 pulse ends low");

    // R11: mode change during a pulse cancels it, event ignored
    conv(1'b0, 1'b0);
    chk(1'b1, "R11 pulse started");
    mode = 2'b01; conv_done = 1'b1; step_last = 1'b1;
    cyc(); clear_in();
    chk(1'b1, "R11 mode change releases");
    cyc();
    chk(1'b1, "R11 pulse cancelled");

    // ---- modes 01 and 10: all flag combinations
    for (int m = 1; m <= 2; m++) begin
      if (mode != 2'(m)) begin
        mode = 2'(m);
        cyc();
        chk(1'b1, "R11 mode switch");
      end
      for (int f = 0; f < 4; f++) begin
        logic s, q, e;
        s = f[0]; q = f[1];
        e = (m == 1) ? s : q;
        conv(s, q);
        chk(~e, (m == 1) ? "R3 step-end qualification" : "R4 sequence-end qualification");
        rd();
        chk(1'b1, "R7 read releases");
      end
      step_last = 1'b1; seq_last = 1'b1;
      cyc(); clear_in();
      chk(1'b1, "R3/R4 flags without strobe ignored");
    end

    // ---- mode 11: FIFO hysteresis
    mode = 2'b11;
    conv_done = 1'b1;
    cyc(); clear_in();
    chk(1'b1, "R11 switch to fifo");

    // worked example: thresholds 5 and 4, filling from empty
    thr_a = 4'd5; thr_b = 4'd4;
    for (int d = 0; d <= 6; d++) begin
      fifo_depth = DW'(d);
      cyc();
      chk((d == 6) ? 1'b0 : 1'b1, "R8 fill to six");
    end
    fifo_depth = 4'd5; cyc(); chk(1'b0, "R10 depth 5 holds");
    fifo_depth = 4'd4; cyc(); chk(1'b1, "R9 depth 4 releases");

    // R12: strobes ignored in fifo mode, both levels
    fifo_depth = 4'd5; conv_done = 1'b1;
    cyc(); clear_in();
    chk(1'b1, "R12 conv ignored in band");
    fifo_depth = 4'd9; cyc(); chk(1'b0, "R8 above band");
    fifo_depth = 4'd5; rd_strobe = 1'b1;
    cyc(); clear_in();
    chk(1'b0, "R12 read ignored in band");

    // exhaustive sweep of thresholds, prior level and depth
    for (int a = 0; a <= DMAX; a++) begin
      for (int b = 0; b <= DMAX; b++) begin
        int hi, lo;
        hi = (a >= b) ? a : b;
        lo = (a >= b) ? b : a;
        thr_a = DW'(a); thr_b = DW'(b);
        for (int s = 0; s < 2; s++) begin
          if (s == 1 && hi == DMAX) continue;
          for (int d = 0; d <= DMAX; d++) begin
            logic prior, exp;
            fifo_depth = (s == 0) ? '0 : DW'(DMAX);
            cyc();
            prior = (s == 0) ? 1'b1 : 1'b0;
            fifo_depth = DW'(d);
            conv_done = d[0]; rd_strobe = d[1];
            cyc(); clear_in();
            if (d > hi) begin
              exp = 1'b0; chk(exp, "R8 sweep above band");
            end else if (d <= lo) begin
              exp = 1'b1; chk(exp, "R9 sweep at or below band");
            end else begin
              exp = prior; chk(exp, "R10 sweep inside band");
            end
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule